// File: doc/BRIEF.md
# Four-Way Write-Through Data Cache with Tree Replacement

This block sits between a processor's word-wide load/store port and an external memory port. It holds 8 KB as 128 sets of four ways, with 16-byte lines. A byte address splits into a tag in bits [31:11], a set index in bits [10:4] and a word select in bits [3:2]. A read that hits returns data one cycle after it is accepted. A read that misses on a cacheable access fetches the whole line from memory, one word at a time in ascending order, and then returns the requested word. Every write goes out to memory. A write also updates the cached copy when the line is present, and never allocates a line.

Whether a read miss may allocate depends on three things: a per-access page-level cache-disable flag, an external enable input, and a cache-disable control bit. A second control bit stops write hits from touching the array. Together with a flush, the two control bits take the cache fully out of service. The flush input drops every valid bit and holds the request port busy for as long as it stays high. Victims are chosen from the invalid ways first, and otherwise by a three-bit tree per set.

Top module: `wt_cache4`

## Requirements
- R1: A read that hits raises cpu_rvalid with the addressed word in the first cycle after the request is accepted, and makes no memory read.
- R2: A cacheable read miss makes exactly four memory word reads of the line, at line offsets 0, 4, 8 and 12 in that order. It then returns the requested word, and later reads of that line hit.
- R3: When a line is allocated, the victim is the lowest-numbered invalid way. If all four ways are valid, the tree decides: bit 0 set picks the pair {2,3}, clear picks {0,1}; bit 1 set picks way 1, clear way 0; bit 2 set picks way 3, clear way 2. On every hit and every fill, the bits on the used way's path are set to point away from it.
- R4: Every accepted write makes exactly one memory write carrying its address and data. A write never raises cpu_rvalid.
- R5: A write that misses allocates nothing, so a later read of that line misses.
- R6: A write that hits also updates the cached word, so a later read hit returns the new value with no memory read.
- R7: With cpu_pcd=1, a read miss makes one single-word memory read and allocates nothing. A read hit is still served from the cache.
- R8: With ext_cache_en=0 or ctl_cd=1, a read miss makes one single-word memory read and allocates nothing. Lines already present still hit.
- R9: With ctl_cd=1 and ctl_nw=1, a write hit goes to memory but leaves the cached word unchanged. After a flush in this mode, every read goes to memory.
- R10: While flush is high, cpu_ready is low and all valid bits are cleared, so every earlier line misses afterwards.
- R11: After reset, cpu_ready is high, mem_req and cpu_rvalid are low, and every line is invalid.
- R12: Once raised, mem_req, mem_we and mem_addr hold steady until mem_ack is sampled high. Each ack completes one word transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Write data |
| cpu_pcd | input | 1 | Page-level cache disable for this access |
| cpu_ready | output | 1 | Port idle and able to accept |
| cpu_rvalid | output | 1 | Read data valid, one cycle pulse |
| cpu_rdata | output | 32 | Read data |
| ext_cache_en | input | 1 | External cache enable |
| ctl_cd | input | 1 | Control: cache disable (no fills) |
| ctl_nw | input | 1 | Control: with ctl_cd, write hits not stored |
| flush | input | 1 | Invalidate all lines, busy while high |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory transfer done, read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
Reads are swept over several sets and all four ways. Each read is done once cold and once warm, and the count of memory reads tells a hit, a line fill and a single-word access apart. A fixed sequence of six tags in one set settles the replacement order: the invalid-first choice and each path through the tree give different miss/hit patterns. Writes are issued as hits and as misses. The memory model's contents and a following read show whether the array was updated or allocated. The cacheability controls are toggled one at a time, and the control-bit pair is combined with flush, to separate "no fill" from "hit still served" from "fully off".

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_RD1,
    ST_WR,
    ST_RESP
  } wtc_state_e;
endpackage

// File: rtl/wtc_sdp_ram.sv
module wtc_sdp_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wtc_plru.sv
module wtc_plru (
  input  logic [2:0] tree_i,
  input  logic [3:0] valid_i,
  input  logic [1:0] use_way_i,
  output logic [1:0] victim_o,
  output logic [2:0] tree_o
);
  always_comb begin
    if (!valid_i[0])      victim_o = 2'd0;
    else if (!valid_i[1]) victim_o = 2'd1;
    else if (!valid_i[2]) victim_o = 2'd2;
    else if (!valid_i[3]) victim_o = 2'd3;
    else if (tree_i[0])   victim_o = {1'b1, tree_i[2]};
    else                  victim_o = {1'b0, tree_i[1]};
  end

  always_comb begin
    tree_o = tree_i;
    if (!use_way_i[1]) begin
      tree_o[0] = 1'b1;
      tree_o[1] = ~use_way_i[0];
    end else begin
      tree_o[0] = 1'b0;
      tree_o[2] = ~use_way_i[0];
    end
  end
endmodule

// File: rtl/wt_cache4.sv
module wt_cache4
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_pcd,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              ext_cache_en,
  input  logic              ctl_cd,
  input  logic              ctl_nw,
  input  logic              flush,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int WAYS   = 4;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = WSEL_W + BYTE_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int DA_W   = IDX_W + WSEL_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  wtc_state_e state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, resp_q;
  logic              we_q, alloc_q;
  logic [1:0]        victim_q;
  logic [WSEL_W-1:0] beat_q;
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [SETS-1:0][2:0]      plru_q;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx, rd_idx;
  logic [WSEL_W-1:0] a_word, rd_word;
  assign a_tag   = addr_q[ADDR_W-1 -: TAG_W];
  assign a_idx   = addr_q[OFF_W +: IDX_W];
  assign a_word  = addr_q[BYTE_W +: WSEL_W];
  assign rd_idx  = cpu_addr[OFF_W +: IDX_W];
  assign rd_word = cpu_addr[BYTE_W +: WSEL_W];

  logic [TAG_W-1:0]  tag_rd  [WAYS];
  logic [DATA_W-1:0] data_rd [WAYS];
  logic [WAYS-1:0]   hit_vec, dwe, twe;
  logic              hit_any, in_look, fill_beat, fill_last, nw_block, plru_upd;
  logic [1:0]        hit_way, victim, use_way;
  logic [2:0]        plru_nxt;
  logic [DATA_W-1:0] hit_data, dwdata;
  logic [DA_W-1:0]   dwaddr;

  always_comb begin
    in_look   = (state_q == ST_LOOK);
    fill_beat = (state_q == ST_FILL) && mem_ack;
    fill_last = fill_beat && (beat_q == LAST_BEAT);
    nw_block  = ctl_cd && ctl_nw;
    hit_way   = 2'd0;
    hit_data  = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[a_idx][w] && (tag_rd[w] == a_tag);
      if (hit_vec[w]) begin
        hit_way  = 2'(w);
        hit_data = data_rd[w];
      end
    end
    hit_any  = |hit_vec;
    use_way  = (state_q == ST_FILL) ? victim_q : hit_way;
    plru_upd = (in_look && hit_any) || fill_last;
    dwaddr   = (state_q == ST_FILL) ? {a_idx, beat_q} : {a_idx, a_word};
    dwdata   = (state_q == ST_FILL) ? mem_rdata : wdata_q;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign dwe[w] = (fill_beat && victim_q == 2'(w)) ||
                    (in_look && we_q && hit_vec[w] && !nw_block);
    assign twe[w] = fill_last && (victim_q == 2'(w));

    wtc_sdp_ram #(.WIDTH(TAG_W), .DEPTH(SETS)) u_tag (
      .clk   (clk),
      .we    (twe[w]),
      .waddr (a_idx),
      .wdata (a_tag),
      .raddr (rd_idx),
      .rdata (tag_rd[w])
    );

    wtc_sdp_ram #(.WIDTH(DATA_W), .DEPTH(SETS * LINE_WORDS)) u_data (
      .clk   (clk),
      .we    (dwe[w]),
      .waddr (dwaddr),
      .wdata (dwdata),
      .raddr ({rd_idx, rd_word}),
      .rdata (data_rd[w])
    );
  end

  wtc_plru u_plru (
    .tree_i    (plru_q[a_idx]),
    .valid_i   (valid_q[a_idx]),
    .use_way_i (use_way),
    .victim_o  (victim),
    .tree_o    (plru_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      plru_q  <= '0;
    end else begin
      if (flush)          valid_q <= '0;
      else if (fill_last) valid_q[a_idx][victim_q] <= 1'b1;
      if (plru_upd)       plru_q[a_idx] <= plru_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      alloc_q  <= 1'b0;
      victim_q <= 2'd0;
      beat_q   <= '0;
      resp_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cpu_req && cpu_ready) begin
          addr_q  <= cpu_addr;
          wdata_q <= cpu_wdata;
          we_q    <= cpu_we;
          alloc_q <= !cpu_pcd && ext_cache_en && !ctl_cd;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (we_q)         state_q <= ST_WR;
          else if (hit_any) state_q <= ST_IDLE;
          else if (alloc_q) begin
            state_q  <= ST_FILL;
            victim_q <= victim;
            beat_q   <= '0;
          end else          state_q <= ST_RD1;
        end
        ST_FILL: if (mem_ack) begin
          if (beat_q == a_word) resp_q <= mem_rdata;
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_q <= ST_RESP;
        end
        ST_RD1: if (mem_ack) begin
          resp_q  <= mem_rdata;
          state_q <= ST_RESP;
        end
        ST_WR:   if (mem_ack) state_q <= ST_IDLE;
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready  = (state_q == ST_IDLE) && !flush;
  assign cpu_rvalid = (in_look && !we_q && hit_any) || (state_q == ST_RESP);
  assign cpu_rdata  = (state_q == ST_RESP) ? resp_q : hit_data;
  assign mem_req    = (state_q == ST_FILL) || (state_q == ST_RD1) || (state_q == ST_WR);
  assign mem_we     = (state_q == ST_WR);
  assign mem_addr   = (state_q == ST_FILL) ? {a_tag, a_idx, beat_q, BYTE_W'(0)} : addr_q;
  assign mem_wdata  = wdata_q;
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              flush,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  logic wr_pend;

  always_ff @(posedge clk) begin
    if (rst)                       wr_pend <= 1'b0;
    else if (cpu_req && cpu_ready) wr_pend <= cpu_we;
    else if (cpu_ready)            wr_pend <= 1'b0;
  end

  a_r10_flush_busy: assert property (@(posedge clk) disable iff (rst)
    flush |-> !cpu_ready);

  a_r1_rvalid_busy: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> !cpu_ready);

  a_r1_accept_then_busy: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready) |=> !cpu_ready);

  a_r4_write_silent: assert property (@(posedge clk) disable iff (rst)
    wr_pend |-> !cpu_rvalid);

  a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r12_we_needs_req: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  a_r11_idle_no_mem: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_req);
endmodule

bind wt_cache4 wtc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .cpu_ready  (cpu_ready),
  .cpu_rvalid (cpu_rvalid),
  .flush      (flush),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr)
);

// File: tb/wt_cache4_tb.sv
`timescale 1ns/1ps
module wt_cache4_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_pcd = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        ext_cache_en = 1'b1, ctl_cd = 1'b0, ctl_nw = 1'b0, flush = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] mdata [4096];
  logic [31:0] rd_log [8];
  bit done = 0;

  always #5 clk = ~clk;

  wt_cache4 dut_i (.*);

  function automatic logic [31:0] init_val(int i);
    return (32'(i) * 32'h0001_0103) ^ 32'h3C00_0000;
  endfunction

  function automatic logic [31:0] A(int t, int s, int w);
    return 32'((t << 11) | (s << 4) | (w << 2));
  endfunction

  always @(negedge clk) begin
    if (rst) mem_ack = 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mdata[mem_addr[13:2]] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata = mdata[mem_addr[13:2]];
        if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
        rd_cnt++;
      end
    end else mem_ack = 1'b0;
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, input logic pcd, output logic [31:0] d,
                    output int lat, output int nrd);
    int base;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    base = rd_cnt;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_pcd = pcd;
    @(negedge clk);
    cpu_req = 1'b0; cpu_pcd = 1'b0;
    lat = 1;
    while (!cpu_rvalid) begin @(negedge clk); lat++; end
    d = cpu_rdata;
    nrd = rd_cnt - base;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] v, output int nwr);
    int base;
    bit saw_rv;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    base = wr_cnt;
    saw_rv = 0;
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    while (!cpu_ready) begin
      if (cpu_rvalid) saw_rv = 1;
      @(negedge clk);
    end
    nwr = wr_cnt - base;
    check("R4 no rvalid on write", 32'(saw_rv), 0);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 busy during flush", 32'(cpu_ready), 0);
    end
    flush = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    int lat, n;
    for (int i = 0; i < 4096; i++) mdata[i] = init_val(i);
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R11 ready after reset", 32'(cpu_ready), 1);
    check("R11 no mem_req after reset", 32'(mem_req), 0);
    check("R11 no rvalid after reset", 32'(cpu_rvalid), 0);

    // R2 fill order and count
    rd(A(0,0,2), 0, d, lat, n);
    check("R2 fill reads", n, 4);
    check("R2 fill data", d, init_val(A(0,0,2) >> 2));
    for (int w = 0; w < 4; w++) check("R2 ascending order", rd_log[w], A(0,0,w));
    rd(A(0,0,2), 0, d, lat, n);
    check("R1 hit latency", lat, 1);
    check("R1 hit no memory", n, 0);
    check("R1 hit data", d, init_val(A(0,0,2) >> 2));

    // R11 all lines invalid, R2/R1 sweep over sets and ways
    for (int s = 1; s <= 4; s++)
      for (int t = 0; t < 4; t++) begin
        rd(A(t,s,t), 0, d, lat, n);
        check("R11/R2 cold miss fills", n, 4);
        check("R2 miss data", d, init_val(A(t,s,t) >> 2));
      end
    for (int s = 1; s <= 4; s++)
      for (int t = 0; t < 4; t++)
        for (int w = 0; w < 4; w++) begin
          rd(A(t,s,w), 0, d, lat, n);
          check("R1 sweep hit", n, 0);
          check("R1 sweep data", d, init_val(A(t,s,w) >> 2));
        end

    // R3 replacement sequence in set 5
    for (int t = 0; t < 4; t++) begin
      rd(A(t,5,0), 0, d, lat, n);
      check("R3 invalid-first fill", n, 4);
    end
    rd(A(4,5,0), 0, d, lat, n); check("R3 t4 miss", n, 4);
    rd(A(0,5,0), 0, d, lat, n); check("R3 t0 evicted", n, 4);
    rd(A(1,5,0), 0, d, lat, n); check("R3 t1 kept", n, 0);
    rd(A(3,5,0), 0, d, lat, n); check("R3 t3 kept", n, 0);
    rd(A(2,5,0), 0, d, lat, n); check("R3 t2 evicted", n, 4);
    rd(A(4,5,0), 0, d, lat, n); check("R3 t4 evicted", n, 4);

    // R4/R6 write hit
    wr(A(0,0,1), 32'hDEAD_BEEF, n);
    check("R4 write hit to memory", n, 1);
    check("R4 memory data", mdata[A(0,0,1) >> 2], 32'hDEAD_BEEF);
    rd(A(0,0,1), 0, d, lat, n);
    check("R6 write hit read no memory", n, 0);
    check("R6 write hit data", d, 32'hDEAD_BEEF);

    // R5 write miss
    wr(A(6,9,0), 32'h1234_5678, n);
    check("R4 write miss to memory", n, 1);
    rd(A(6,9,0), 0, d, lat, n);
    check("R5 no allocate on write miss", n, 4);
    check("R5 data", d, 32'h1234_5678);

    // R7 page disable
    rd(A(1,10,3), 1, d, lat, n);
    check("R7 single read", n, 1);
    check("R7 data", d, init_val(A(1,10,3) >> 2));
    rd(A(1,10,3), 0, d, lat, n);
    check("R7 not allocated", n, 4);
    rd(A(1,10,3), 1, d, lat, n);
    check("R7 hit still served", n, 0);

    // R8 external enable low
    ext_cache_en = 1'b0;
    rd(A(1,11,2), 0, d, lat, n); check("R8 ext off single", n, 1);
    rd(A(1,11,2), 0, d, lat, n); check("R8 ext off no alloc", n, 1);
    rd(A(0,0,2), 0, d, lat, n);  check("R8 ext off hit", n, 0);
    ext_cache_en = 1'b1;

    // R8 control disable
    ctl_cd = 1'b1;
    rd(A(1,12,0), 0, d, lat, n); check("R8 cd single", n, 1);
    rd(A(1,12,0), 0, d, lat, n); check("R8 cd no alloc", n, 1);
    check("R8 cd data", d, init_val(A(1,12,0) >> 2));

    // R9 both control bits
    ctl_nw = 1'b1;
    wr(A(0,0,3), 32'hA5A5_5A5A, n);
    check("R9 write to memory", n, 1);
    rd(A(0,0,3), 0, d, lat, n);
    check("R9 hit served", n, 0);
    check("R9 cache not updated", d, init_val(A(0,0,3) >> 2));
    do_flush();
    rd(A(0,0,3), 0, d, lat, n);
    check("R9 off after flush", n, 1);
    check("R9 memory data", d, 32'hA5A5_5A5A);
    rd(A(0,0,3), 0, d, lat, n);
    check("R9 still off", n, 1);
    ctl_cd = 1'b0; ctl_nw = 1'b0;

    // R10 flush invalidates
    rd(A(2,13,1), 0, d, lat, n); check("R10 setup fill", n, 4);
    rd(A(2,13,1), 0, d, lat, n); check("R10 setup hit", n, 0);
    do_flush();
    @(negedge clk);
    check("R10 ready after flush", 32'(cpu_ready), 1);
    rd(A(2,13,1), 0, d, lat, n); check("R10 miss after flush", n, 4);
    check("R10 data", d, init_val(A(2,13,1) >> 2));

    done = 1;
    summary();
  end
endmodule